// File: doc/BRIEF.md
# Biphase-Mark Subframe Line Encoder

This block turns a serial stream of digital audio subframe bits into a biphase-mark line signal. One clock enable marks each half-bit cell. Every bit slot therefore takes two enabled cycles, and the line level of each cell comes out on a single registered pin. A subframe holds 32 bit slots. The first four slots carry a synchronising preamble, and the other 28 slots are encoded from the serial data input.

The preamble is built from two code-violation symbols that break the biphase rule on purpose, so that no data pattern can imitate it. Its polarity follows the line level at the moment the subframe starts. The caller strobes a subframe start together with a left/right flag:
- A right subframe gets the Y preamble.
- A left subframe gets the X preamble, except at the start of each 192-frame block. There it gets Z.

An internal block counter advances on each accepted left subframe and decides when Z is due. The block asks for each data bit one enabled cycle before it takes it. Back-to-back subframes join without a gap when the next start is strobed during the final cell.

Top module: `bmc_encoder`

## Requirements
- R1: While rst_ni is low, line_o and cv_o are 0 and bit_req_o is 0. After reset the block is idle, the line level is 0 and the block counter is 0, so the first left subframe carries Z.
- R2: Each data slot (slots 4 to 31) begins with a cell whose level is the inverse of the previous cell, so every bit boundary outside the preamble has a transition.
- R3: In a data slot, a data bit of 1 makes the second cell differ from the first, and a data bit of 0 makes the two cells equal. data_i is taken on the enabled edge that follows a cycle with bit_req_o high. The first bit taken goes into slot 4.
- R4: The Z preamble sends the 8 cells 11101000 (first cell first) when the line was low before the subframe, and 00010111 when it was high.
- R5: The X preamble sends 11100010 from a low prior level and 00011101 from a high one.
- R6: The Y preamble sends 11100100 from a low prior level and 00011011 from a high one.
- R7: A subframe started with chan_right_i = 1 carries Y. One started with chan_right_i = 0 carries X or Z.
- R8: The block counter runs 0 to 191, advances once per accepted left subframe and wraps after 191. A left subframe accepted while it reads 0 carries Z, so Z appears once every 192 frames.
- R9: cv_o is 1 for both cells of a violation slot and 0 otherwise: Z in slots 1 and 3, X and Y in slots 1 and 2. It is 0 in all data slots and while idle.
- R10: sf_start_i is ignored during a subframe except in its last cell. There it starts the next subframe with no idle cell between them.
- R11: While cell_en_i is low, line_o, cv_o and the slot position hold.
- R12: While idle and with no start strobe, line_o holds its level and bit_req_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_en_i | input | 1 | Advance by one half-bit cell on this edge |
| sf_start_i | input | 1 | Request to start a subframe |
| chan_right_i | input | 1 | Subframe carries the right sample (1) or the left sample (0) |
| data_i | input | 1 | Serial data bit for the next data slot |
| line_o | output | 1 | Biphase-mark line level of the current cell |
| cv_o | output | 1 | Current slot is a code-violation symbol |
| bit_req_o | output | 1 | data_i is taken on the next enabled edge |

## Verification
An accepted start shows its first preamble cell on line_o right after the accepting edge, since only the output register lies on that path. Each later cell follows one enabled edge after the one before. A data bit driven while bit_req_o is high first affects the second cell of its slot, two enabled edges later. The bench drives inputs on the falling edge and reads one cell per cycle on the next falling edge. It rebuilds the 64 cells it expects from the prior line level, the preamble kind given by its own frame count, and the data word. While cell_en_i is held low, and while idle, it reads the line on every falling edge so that a single stray cell cannot slip past.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  localparam int unsigned PRE_SLOTS = 4;

  typedef enum logic [1:0] {
    PRE_Z = 2'd0,
    PRE_X = 2'd1,
    PRE_Y = 2'd2
  } pre_kind_e;

  // d: mid-slot toggle, cv: invert both cells of the slot
  typedef struct packed {
    logic d;
    logic cv;
  } sym_t;

  // Preamble as four symbols; the violation symbols are plain bits with cv set
  function automatic sym_t pre_sym(pre_kind_e kind, logic [1:0] idx);
    sym_t s;
    s = '{d: 1'b0, cv: 1'b0};
    case (idx)
      2'd0: s = '{d: 1'b0, cv: 1'b0};
      2'd1: s = '{d: 1'b1, cv: 1'b1};
      2'd2: begin
        case (kind)
          PRE_Z:   s = '{d: 1'b1, cv: 1'b0};
          PRE_X:   s = '{d: 1'b0, cv: 1'b1};
          default: s = '{d: 1'b1, cv: 1'b1};
        endcase
      end
      default: begin
        case (kind)
          PRE_Z:   s = '{d: 1'b0, cv: 1'b1};
          PRE_X:   s = '{d: 1'b1, cv: 1'b0};
          default: s = '{d: 1'b0, cv: 1'b0};
        endcase
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/bmc_block_ctr.sv
module bmc_block_ctr #(
  parameter int unsigned FRAMES = 192,
  localparam int unsigned CW = $clog2(FRAMES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [CW-1:0] cnt_o,
  output logic          first_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (adv_i) begin
      cnt_q <= (cnt_q == CW'(FRAMES - 1)) ? '0 : cnt_q + 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign first_o = (cnt_q == '0);

endmodule

// File: rtl/bmc_slot_seq.sv
module bmc_slot_seq #(
  parameter int unsigned SLOTS     = 32,
  parameter int unsigned PRE_SLOTS = 4,
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cell_en_i,
  input  logic          sf_start_i,
  output logic          active_o,
  output logic [SW-1:0] slot_o,
  output logic          half_o,
  output logic          start_o,
  output logic          open_o,
  output logic          close_o,
  output logic [SW-1:0] nxt_slot_o,
  output logic          bit_req_o
);

  logic          active_q, half_q, last_cell, start;
  logic [SW-1:0] slot_q;

  assign last_cell = active_q && half_q && (slot_q == SW'(SLOTS - 1));
  // start only when idle or on the final cell
  assign start     = cell_en_i && sf_start_i && (!active_q || last_cell);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      half_q   <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      slot_q   <= '0;
      half_q   <= 1'b0;
    end else if (cell_en_i && active_q) begin
      if (!half_q) begin
        half_q <= 1'b1;
      end else if (last_cell) begin
        active_q <= 1'b0;
        slot_q   <= '0;
        half_q   <= 1'b0;
      end else begin
        slot_q <= slot_q + 1'b1;
        half_q <= 1'b0;
      end
    end
  end

  assign active_o   = active_q;
  assign slot_o     = slot_q;
  assign half_o     = half_q;
  assign start_o    = start;
  assign open_o     = start || (cell_en_i && active_q && half_q && !last_cell);
  assign close_o    = cell_en_i && active_q && !half_q;
  assign nxt_slot_o = start ? '0 : slot_q + 1'b1;
  assign bit_req_o  = active_q && half_q &&
                      (slot_q >= SW'(PRE_SLOTS - 1)) &&
                      (slot_q <  SW'(SLOTS - 1));

endmodule

// File: rtl/bmc_cell_gen.sv
module bmc_cell_gen
  import bmc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic open_i,
  input  logic close_i,
  input  sym_t sym_i,
  output logic line_o,
  output logic cv_o,
  output logic dbit_o
);

  logic line_q, cv_q, dbit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      cv_q   <= 1'b0;
      dbit_q <= 1'b0;
    end else if (open_i) begin
      // boundary toggle, cancelled by a violation
      line_q <= ~line_q ^ sym_i.cv;
      cv_q   <= sym_i.cv;
      dbit_q <= sym_i.d;
    end else if (close_i) begin
      line_q <= line_q ^ dbit_q;
    end
  end

  assign line_o = line_q;
  assign cv_o   = cv_q;
  assign dbit_o = dbit_q;

endmodule

// File: rtl/bmc_encoder.sv
module bmc_encoder
  import bmc_pkg::*;
#(
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned FRAMES = 192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cell_en_i,
  input  logic sf_start_i,
  input  logic chan_right_i,
  input  logic data_i,
  output logic line_o,
  output logic cv_o,
  output logic bit_req_o
);

  localparam int unsigned SW = $clog2(SLOTS);
  localparam int unsigned CW = $clog2(FRAMES);

  logic          sf_active, half_q, start, open_slot, close_slot;
  logic          blk_first, dbit;
  logic [SW-1:0] slot_q, nxt_slot;
  logic [CW-1:0] blk_cnt;
  pre_kind_e     kind_q, kind_nxt, kind_sel;
  sym_t          sym;

  bmc_slot_seq #(
    .SLOTS    (SLOTS),
    .PRE_SLOTS(PRE_SLOTS)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cell_en_i (cell_en_i),
    .sf_start_i(sf_start_i),
    .active_o  (sf_active),
    .slot_o    (slot_q),
    .half_o    (half_q),
    .start_o   (start),
    .open_o    (open_slot),
    .close_o   (close_slot),
    .nxt_slot_o(nxt_slot),
    .bit_req_o (bit_req_o)
  );

  bmc_block_ctr #(
    .FRAMES(FRAMES)
  ) u_blk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (start && !chan_right_i),
    .cnt_o  (blk_cnt),
    .first_o(blk_first)
  );

  always_comb begin
    if (chan_right_i)   kind_nxt = PRE_Y;
    else if (blk_first) kind_nxt = PRE_Z;
    else                kind_nxt = PRE_X;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    kind_q <= PRE_Z;
    else if (start) kind_q <= kind_nxt;
  end

  assign kind_sel = start ? kind_nxt : kind_q;

  always_comb begin
    if (nxt_slot < SW'(PRE_SLOTS)) sym = pre_sym(kind_sel, nxt_slot[1:0]);
    else                           sym = '{d: data_i, cv: 1'b0};
  end

  bmc_cell_gen u_cell (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .open_i (open_slot),
    .close_i(close_slot),
    .sym_i  (sym),
    .line_o (line_o),
    .cv_o   (cv_o),
    .dbit_o (dbit)
  );

endmodule

// File: rtl/bmc_encoder_chk.sv
module bmc_encoder_chk #(
  parameter int unsigned SLOTS     = 32,
  parameter int unsigned FRAMES    = 192,
  parameter int unsigned PRE_SLOTS = 4,
  localparam int unsigned SW = $clog2(SLOTS),
  localparam int unsigned CW = $clog2(FRAMES)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cell_en_i,
  input logic          sf_start_i,
  input logic          line_o,
  input logic          cv_o,
  input logic          bit_req_o,
  input logic          active_i,
  input logic [SW-1:0] slot_i,
  input logic          half_i,
  input logic          dbit_i,
  input logic [CW-1:0] blk_cnt_i
);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!line_o && !cv_o && !bit_req_o && !active_i);
    end
  end

  a_r2_boundary_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_en_i && active_i && half_i && (slot_i >= SW'(PRE_SLOTS - 1)) &&
    (slot_i < SW'(SLOTS - 1))
    |=> line_o != $past(line_o));

  a_r3_mid_cell: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_en_i && active_i && !half_i && (slot_i >= SW'(PRE_SLOTS))
    |=> line_o == ($past(line_o) ^ $past(dbit_i)));

  a_r8_ctr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_cnt_i < CW'(FRAMES));

  a_r9_no_cv_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i || slot_i >= SW'(PRE_SLOTS)) |-> !cv_o);

  a_r10_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_en_i && active_i && !(half_i && slot_i == SW'(SLOTS - 1))
    |=> active_i && (half_i != $past(half_i)));

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cell_en_i |=> $stable(line_o) && $stable(cv_o) && $stable(slot_i) && $stable(half_i));

  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_en_i && !active_i && !sf_start_i |=> $stable(line_o) && !active_i && !bit_req_o);

endmodule

bind bmc_encoder bmc_encoder_chk #(
  .SLOTS (SLOTS),
  .FRAMES(FRAMES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cell_en_i (cell_en_i),
  .sf_start_i(sf_start_i),
  .line_o    (line_o),
  .cv_o      (cv_o),
  .bit_req_o (bit_req_o),
  .active_i  (sf_active),
  .slot_i    (slot_q),
  .half_i    (half_q),
  .dbit_i    (dbit),
  .blk_cnt_i (blk_cnt)
);

// File: tb/sim_bmc_encoder.sv
module sim_bmc_encoder;

  localparam int CLK_P  = 10;
  localparam int FRAMES = 192;

  logic clk_i = 1'b0;
  logic rst_ni, cell_en_i, sf_start_i, chan_right_i, data_i;
  logic line_o, cv_o, bit_req_o;

  int checks = 0;
  int errors = 0;
  int mdl_cnt = 0;
  int z_seen = 0;
  bit done = 1'b0;

  bmc_encoder u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cell_en_i   (cell_en_i),
    .sf_start_i  (sf_start_i),
    .chan_right_i(chan_right_i),
    .data_i      (data_i),
    .line_o      (line_o),
    .cv_o        (cv_o),
    .bit_req_o   (bit_req_o)
  );

  always #(CLK_P / 2) clk_i = ~clk_i;

  typedef struct packed {
    logic        right;
    logic [27:0] dat;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{right: 1'b0, dat: 28'h0000000},
    '{right: 1'b1, dat: 28'hFFFFFFF},
    '{right: 1'b0, dat: 28'h5555555},
    '{right: 1'b1, dat: 28'hAAAAAAA},
    '{right: 1'b0, dat: 28'h8000001},
    '{right: 1'b1, dat: 28'h1234567},
    '{right: 1'b0, dat: 28'hFEDCBA9},
    '{right: 1'b1, dat: 28'h0F0F0F0}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] pre_base(input int k);
    case (k)
      0:       return 8'b11101000;
      1:       return 8'b11100010;
      default: return 8'b11100100;
    endcase
  endfunction

  // k: 0 = Z, 1 = X, 2 = Y; stall_at/glitch_at: cell index or -1
  task automatic send_sf(input logic right, input logic [27:0] dat,
                         input int stall_at, input int glitch_at);
    int k, nb;
    logic lvl, l, hold_l, hold_ok, any_cv;
    logic [7:0] pre, got_p, got_cv, exp_cv;
    logic [55:0] exp_d, got_d;
    string ptag;
    if (right) k = 2;
    else begin
      k = (mdl_cnt == 0) ? 0 : 1;
      mdl_cnt = (mdl_cnt == FRAMES - 1) ? 0 : mdl_cnt + 1;
    end
    lvl = line_o;
    pre = pre_base(k) ^ {8{lvl}};
    l = pre[0];
    for (int b = 0; b < 28; b++) begin
      exp_d[55 - 2 * b] = ~l;
      exp_d[54 - 2 * b] = ~l ^ dat[b];
      l = ~l ^ dat[b];
    end
    exp_cv = (k == 0) ? 8'h33 : 8'h3C;
    ptag = (k == 0) ? "R4 R8 Z preamble" : (k == 1) ? "R5 R7 X preamble" : "R6 R7 Y preamble";
    any_cv = 1'b0;
    hold_ok = 1'b1;
    nb = 0;
    got_p = '0; got_cv = '0; got_d = '0;
    sf_start_i = 1'b1;
    chan_right_i = right;
    for (int i = 0; i < 64; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      sf_start_i = 1'b0;
      if (i < 8) begin
        got_p[7 - i]  = line_o;
        got_cv[7 - i] = cv_o;
      end else begin
        got_d[63 - i] = line_o;
        if (cv_o) any_cv = 1'b1;
      end
      if (bit_req_o && nb < 28) begin
        data_i = dat[nb];
        nb++;
      end
      if (i == glitch_at) begin
        sf_start_i = 1'b1;
        chan_right_i = ~right;
      end
      if (i == stall_at) begin
        hold_l = line_o;
        cell_en_i = 1'b0;
        for (int s = 0; s < 5; s++) begin
          @(posedge clk_i);
          @(negedge clk_i);
          if (line_o !== hold_l) hold_ok = 1'b0;
        end
        cell_en_i = 1'b1;
        chk("R11 line held while cell_en_i low", {63'd0, hold_ok}, 64'd1);
      end
    end
    chk(ptag, {56'd0, got_p}, {56'd0, pre});
    chk("R2 R3 data cells", {8'd0, got_d}, {8'd0, exp_d});
    chk("R9 preamble violation flag", {56'd0, got_cv}, {56'd0, exp_cv});
    chk("R9 no violation flag in data", {63'd0, any_cv}, 64'd0);
    chk("R3 data bits requested", 64'(nb), 64'd28);
    if (got_p == 8'b11101000 || got_p == 8'b00010111) z_seen++;
  endtask

  task automatic idle_check(input int n);
    logic hold_l, ok;
    hold_l = line_o;
    ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (line_o !== hold_l || bit_req_o !== 1'b0 || cv_o !== 1'b0) ok = 1'b0;
    end
    chk("R12 idle holds line", {63'd0, ok}, 64'd1);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    sf_start_i = 1'b0;
    #1;
    chk("R1 reset line/cv/req", {61'd0, line_o, cv_o, bit_req_o}, 64'd0);
    @(negedge clk_i);
    chk("R1 reset held", {61'd0, line_o, cv_o, bit_req_o}, 64'd0);
    rst_ni = 1'b1;
    mdl_cnt = 0;
    z_seen = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b1;
    cell_en_i = 1'b1;
    sf_start_i = 1'b0;
    chan_right_i = 1'b0;
    data_i = 1'b0;
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset state", {61'd0, line_o, cv_o, bit_req_o}, 64'd0);
    rst_ni = 1'b1;
    idle_check(4);

    // table walk, back-to-back subframes; first left after reset is Z (R1 R8)
    foreach (VECS[v]) send_sf(VECS[v].right, VECS[v].dat, -1, -1);
    chk("R8 one Z in table walk", 64'(z_seen), 64'd1);
    idle_check(6);

    send_sf(1'b0, 28'h3C3C3C3, 20, -1);
    send_sf(1'b1, 28'h7777777, 3, -1);
    send_sf(1'b0, 28'h0000001, -1, 30);
    send_sf(1'b1, 28'h1000000, -1, 5);
    idle_check(3);

    // reset with line possibly high, then a full block and one more frame
    do_reset();
    chk("R1 line low after reset", {63'd0, line_o}, 64'd0);
    for (int f = 0; f < FRAMES + 1; f++) begin
      send_sf(1'b0, 28'(f * 32'h9E3779B1), -1, -1);
      send_sf(1'b1, 28'(f * 32'h85EBCA6B), -1, -1);
    end
    chk("R8 Z once per 192 frames", 64'(z_seen), 64'd2);
    idle_check(4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule